// File: doc/BRIEF.md
# CPU Extension Coprocessor Unit

This unit is a small arithmetic coprocessor that sits next to a 32-bit CPU core and carries out user-defined extension instructions. Each command has a 6-bit extension code and a 32-bit operand. Commands fall into two groups. Result codes compute a value, and the CPU writes that value into one of its data registers. Transfer codes return nothing. They only place an operand into an internal staging register, or clear the accumulator.

An operation that needs more inputs than one command can carry is issued as a sequence. First, transfer codes load the extra inputs into the staging registers. Then a single result code uses the operand together with those staged values. The datapath contains a signed 32×16 multiplier, a 64-bit accumulator, a signed saturation stage and a highest-set-bit encoder.

The command side uses a valid/ready handshake. The result side has a one-cycle valid strobe and a 32-bit data bus. The CPU's fetch, register writeback and interlock logic are outside this block.

Top module: `xcop_unit`

## Requirements
- R1: A synchronous active-high reset clears staging registers S0, S1, S2 and the 64-bit accumulator to zero, drives `res_valid` low and leaves `cmd_ready` high.
- R2: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. For an accepted result code (0 to 15), `res_valid` is high for exactly the following cycle and `cmd_ready` is low during that cycle only. Transfer and ignored codes never raise `res_valid` and never lower `cmd_ready`.
- R3: Transfer code 20 stores operand bits [15:0] in S0. Code 21 stores operand bits [4:0] in S1. Code 22 stores the full operand in S2.
- R4: Result code 0 returns the low 32 bits of the signed product of the operand and signed S0.
- R5: Result code 1 adds the sign-extended 48-bit product of the operand and signed S0 to the accumulator, and returns the low 32 bits of the updated accumulator. Result code 4 returns the accumulator's upper 32 bits and does not change it.
- R6: Transfer code 23 clears the accumulator.
- R7: Result code 2 returns the operand saturated to a signed width of S1 bits. For a width w from 1 to 31, values above 2^(w-1)-1 or below -2^(w-1) are clamped to that limit. When S1 is 0, the operand is returned unchanged.
- R8: Result code 3 returns the bit index of the highest set bit of the operand, or 32 when the operand is zero.
- R9: Result code 5 returns the low 32 bits of the operand × S0 product, plus S2, modulo 2^32.
- R10: Result codes 6 to 15 return zero and still produce the result strobe.
- R11: Codes 16 to 19 and 36 to 63 are ignored, and so are the reserved transfer codes 24 to 35. None of them changes S0, S1, S2 or the accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit can accept a command |
| cmd_code | input | 6 | Extension code |
| cmd_operand | input | 32 | Register or immediate operand |
| res_valid | output | 1 | Result strobe, one cycle |
| res_data | output | 32 | Result for the CPU data register |

## Verification
The checker tests the handshake timing on every cycle. It confirms that each accepted result code produces exactly one strobe on the next cycle, that no other cycle carries a strobe, and that ready is low whenever a strobe is out. It also confirms that ignored and reserved codes leave the staging registers and accumulator unchanged, and that an encoder result never exceeds 32. The arithmetic values themselves can only be shown by the bench's scenarios. These include negative multiplicands, accumulator carries into the upper word, saturation at widths 0, 1, 8 and 31, a zero operand to the encoder, and staged values read back after junk codes.

// File: rtl/xcop_pkg.sv
`timescale 1ns/1ps
package xcop_pkg;

    localparam int unsigned CODE_W = 6;

    localparam logic [CODE_W-1:0] C_MUL    = 6'd0;
    localparam logic [CODE_W-1:0] C_MAC    = 6'd1;
    localparam logic [CODE_W-1:0] C_SAT    = 6'd2;
    localparam logic [CODE_W-1:0] C_PRI    = 6'd3;
    localparam logic [CODE_W-1:0] C_ACCHI  = 6'd4;
    localparam logic [CODE_W-1:0] C_MADD   = 6'd5;
    localparam logic [CODE_W-1:0] C_RESMAX = 6'd15;
    localparam logic [CODE_W-1:0] C_LDS0   = 6'd20;
    localparam logic [CODE_W-1:0] C_LDS1   = 6'd21;
    localparam logic [CODE_W-1:0] C_LDS2   = 6'd22;
    localparam logic [CODE_W-1:0] C_CLRACC = 6'd23;
    localparam logic [CODE_W-1:0] C_XFMAX  = 6'd35;

    typedef enum logic [2:0] {
        OP_MUL, OP_MAC, OP_SAT, OP_PRI, OP_ACCHI, OP_MADD, OP_ZERO
    } res_op_e;

    typedef enum logic [2:0] {
        XF_NONE, XF_S0, XF_S1, XF_S2, XF_CLR
    } xfer_e;

    typedef struct packed {
        logic    is_res;
        res_op_e op;
        xfer_e   xf;
    } dec_t;

    function automatic dec_t decode_code(input logic [CODE_W-1:0] c);
        dec_t d;
        d.is_res = 1'b0;
        d.op     = OP_ZERO;
        d.xf     = XF_NONE;
        if (c <= C_RESMAX) begin
            d.is_res = 1'b1;
            case (c)
                C_MUL:   d.op = OP_MUL;
                C_MAC:   d.op = OP_MAC;
                C_SAT:   d.op = OP_SAT;
                C_PRI:   d.op = OP_PRI;
                C_ACCHI: d.op = OP_ACCHI;
                C_MADD:  d.op = OP_MADD;
                default: d.op = OP_ZERO;
            endcase
        end else if (c >= C_LDS0 && c <= C_XFMAX) begin
            case (c)
                C_LDS0:   d.xf = XF_S0;
                C_LDS1:   d.xf = XF_S1;
                C_LDS2:   d.xf = XF_S2;
                C_CLRACC: d.xf = XF_CLR;
                default:  d.xf = XF_NONE;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/xcop_decode.sv
`timescale 1ns/1ps
module xcop_decode
    import xcop_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output dec_t              dec
);
    always_comb dec = decode_code(code);
endmodule

// File: rtl/xcop_alu.sv
`timescale 1ns/1ps
module xcop_alu
    import xcop_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned MUL_W  = 16,
    parameter int unsigned ACC_W  = 64,
    parameter int unsigned SAT_W  = 5
) (
    input  res_op_e           op,
    input  logic [DATA_W-1:0] operand,
    input  logic [MUL_W-1:0]  s0,
    input  logic [SAT_W-1:0]  s1,
    input  logic [DATA_W-1:0] s2,
    input  logic [ACC_W-1:0]  acc,
    output logic [ACC_W-1:0]  acc_sum,
    output logic [DATA_W-1:0] result
);
    localparam int unsigned PROD_W = DATA_W + MUL_W;
    localparam int unsigned IDX_W  = $clog2(DATA_W + 1);

    logic signed [PROD_W-1:0] op_x, s0_x, prod;
    logic        [DATA_W-1:0] sat_res, pri_res, madd_res;
    logic signed [DATA_W-1:0] sat_hi, sat_lo;
    logic        [IDX_W-1:0]  pri_idx;

    // signed multiply with explicit sign extension to the product width
    assign op_x = {{MUL_W{operand[DATA_W-1]}}, operand};
    assign s0_x = {{DATA_W{s0[MUL_W-1]}}, s0};
    assign prod = op_x * s0_x;

    assign acc_sum  = acc + {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
    assign madd_res = prod[DATA_W-1:0] + s2;

    // saturation limits for width s1 (zero means pass-through)
    always_comb begin
        sat_hi = DATA_W'(signed'(({{(DATA_W-1){1'b0}}, 1'b1} << (s1 - 1'b1)) - 1'b1));
        sat_lo = ~sat_hi;
        if (s1 == '0)
            sat_res = operand;
        else if ($signed(operand) > sat_hi)
            sat_res = sat_hi;
        else if ($signed(operand) < sat_lo)
            sat_res = sat_lo;
        else
            sat_res = operand;
    end

    // highest set bit, DATA_W when none
    always_comb begin
        pri_idx = IDX_W'(DATA_W);
        for (int i = 0; i < DATA_W; i++)
            if (operand[i]) pri_idx = IDX_W'(i);
        pri_res = DATA_W'(pri_idx);
    end

    always_comb begin
        unique case (op)
            OP_MUL:   result = prod[DATA_W-1:0];
            OP_MAC:   result = acc_sum[DATA_W-1:0];
            OP_SAT:   result = sat_res;
            OP_PRI:   result = pri_res;
            OP_ACCHI: result = acc[ACC_W-1 -: DATA_W];
            OP_MADD:  result = madd_res;
            default:  result = '0;
        endcase
    end
endmodule

// File: rtl/xcop_stage.sv
`timescale 1ns/1ps
module xcop_stage
    import xcop_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned MUL_W  = 16,
    parameter int unsigned ACC_W  = 64,
    parameter int unsigned SAT_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  xfer_e             xf,
    input  logic              acc_ld,
    input  logic [ACC_W-1:0]  acc_nxt,
    input  logic [DATA_W-1:0] operand,
    output logic [MUL_W-1:0]  s0,
    output logic [SAT_W-1:0]  s1,
    output logic [DATA_W-1:0] s2,
    output logic [ACC_W-1:0]  acc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            s0  <= '0;
            s1  <= '0;
            s2  <= '0;
            acc <= '0;
        end else if (wr_en) begin
            case (xf)
                XF_S0:   s0  <= operand[MUL_W-1:0];
                XF_S1:   s1  <= operand[SAT_W-1:0];
                XF_S2:   s2  <= operand;
                XF_CLR:  acc <= '0;
                default: ;
            endcase
            if (acc_ld) acc <= acc_nxt;
        end
    end
endmodule

// File: rtl/xcop_unit.sv
`timescale 1ns/1ps
module xcop_unit
    import xcop_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned MUL_W  = 16,
    parameter int unsigned ACC_W  = 2 * DATA_W,
    parameter int unsigned SAT_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic [DATA_W-1:0] cmd_operand,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data
);
    dec_t              dec;
    logic              accept;
    logic [MUL_W-1:0]  s0_q;
    logic [SAT_W-1:0]  s1_q;
    logic [DATA_W-1:0] s2_q;
    logic [ACC_W-1:0]  acc_q, acc_sum;
    logic [DATA_W-1:0] alu_res;
    logic              valid_q;
    logic [DATA_W-1:0] data_q;

    assign accept    = cmd_valid && cmd_ready;
    assign cmd_ready = ~valid_q;

    xcop_decode u_dec (
        .code (cmd_code),
        .dec  (dec)
    );

    xcop_alu #(.DATA_W(DATA_W), .MUL_W(MUL_W), .ACC_W(ACC_W), .SAT_W(SAT_W)) u_alu (
        .op      (dec.op),
        .operand (cmd_operand),
        .s0      (s0_q),
        .s1      (s1_q),
        .s2      (s2_q),
        .acc     (acc_q),
        .acc_sum (acc_sum),
        .result  (alu_res)
    );

    xcop_stage #(.DATA_W(DATA_W), .MUL_W(MUL_W), .ACC_W(ACC_W), .SAT_W(SAT_W)) u_stage (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (accept),
        .xf      (dec.xf),
        .acc_ld  (dec.is_res && dec.op == OP_MAC),
        .acc_nxt (acc_sum),
        .operand (cmd_operand),
        .s0      (s0_q),
        .s1      (s1_q),
        .s2      (s2_q),
        .acc     (acc_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= accept && dec.is_res;
            if (accept && dec.is_res) data_q <= alu_res;
        end
    end

    assign res_valid = valid_q;
    assign res_data  = data_q;
endmodule

// File: rtl/xcop_unit_chk.sv
`timescale 1ns/1ps
module xcop_unit_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned MUL_W  = 16,
    parameter int unsigned ACC_W  = 64,
    parameter int unsigned SAT_W  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [5:0]        cmd_code,
    input logic              res_valid,
    input logic [DATA_W-1:0] res_data,
    input logic [MUL_W-1:0]  s0,
    input logic [SAT_W-1:0]  s1,
    input logic [DATA_W-1:0] s2,
    input logic [ACC_W-1:0]  acc
);
    logic take, take_res, take_pri, take_inert;

    assign take       = cmd_valid && cmd_ready;
    assign take_res   = take && (cmd_code < 6'd16);
    assign take_pri   = take && (cmd_code == 6'd3);
    assign take_inert = take && !(cmd_code < 6'd16) && !(cmd_code >= 6'd20 && cmd_code <= 6'd23);

    // R2: a strobe follows every accepted result code
    a_r2_strobe_follows: assert property (@(posedge clk) disable iff (rst)
        take_res |=> res_valid);

    // R2 / R11: no strobe without an accepted result code
    a_r2_no_spurious_strobe: assert property (@(posedge clk) disable iff (rst)
        !take_res |=> !res_valid);

    // R2: ready is withdrawn while a result is out
    a_r2_ready_low_on_strobe: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> !cmd_ready);

    // R11: ignored and reserved codes leave all state unchanged
    a_r11_inert_keeps_state: assert property (@(posedge clk) disable iff (rst)
        take_inert |=> ($stable(s0) && $stable(s1) && $stable(s2) && $stable(acc)));

    // R8: the encoder index never exceeds the data width
    a_r8_index_in_range: assert property (@(posedge clk) disable iff (rst)
        take_pri |=> (res_data <= DATA_W));
endmodule

bind xcop_unit xcop_unit_chk #(
    .DATA_W(DATA_W), .MUL_W(MUL_W), .ACC_W(ACC_W), .SAT_W(SAT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_code  (cmd_code),
    .res_valid (res_valid),
    .res_data  (res_data),
    .s0        (s0_q),
    .s1        (s1_q),
    .s2        (s2_q),
    .acc       (acc_q)
);

// File: tb/tb_xcop_unit.sv
`timescale 1ns/1ps
module tb_xcop_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic        cmd_ready;
    logic [5:0]  cmd_code;
    logic [31:0] cmd_operand;
    logic        res_valid;
    logic [31:0] res_data;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    string cur_tag = "R1";

    always #5 clk = ~clk;

    xcop_unit dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_code(cmd_code), .cmd_operand(cmd_operand),
        .res_valid(res_valid), .res_data(res_data)
    );

    // behavioural reference model
    logic [15:0] m_s0;
    logic [4:0]  m_s1;
    logic [31:0] m_s2;
    longint      m_acc;
    logic        m_valid;
    logic [31:0] m_data;
    longint      t_a, t_b, t_p, t_n;
    int          t_c;
    logic [31:0] t_r;

    function automatic logic [31:0] sat_ref(input logic [31:0] v, input logic [4:0] w);
        longint x, hi, lo;
        x = longint'($signed(v));
        if (w == 5'd0) return v;
        hi = (longint'(1) <<< (int'(w) - 1)) - 1;
        lo = -hi - 1;
        if (x > hi) return hi[31:0];
        if (x < lo) return lo[31:0];
        return v;
    endfunction

    function automatic logic [31:0] pri_ref(input logic [31:0] v);
        for (int i = 31; i >= 0; i--)
            if (v[i]) return 32'(i);
        return 32'd32;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_s0 <= '0; m_s1 <= '0; m_s2 <= '0; m_acc <= 0;
            m_valid <= 1'b0; m_data <= '0;
        end else begin
            m_valid <= 1'b0;
            if (cmd_valid && !m_valid) begin
                t_c = int'(cmd_code);
                t_a = longint'($signed(cmd_operand));
                t_b = longint'($signed(m_s0));
                t_p = t_a * t_b;
                if (t_c <= 15) begin
                    case (t_c)
                        0: t_r = t_p[31:0];
                        1: begin t_n = m_acc + t_p; m_acc <= t_n; t_r = t_n[31:0]; end
                        2: t_r = sat_ref(cmd_operand, m_s1);
                        3: t_r = pri_ref(cmd_operand);
                        4: t_r = m_acc[63:32];
                        5: t_r = t_p[31:0] + m_s2;
                        default: t_r = 32'd0;
                    endcase
                    m_valid <= 1'b1;
                    m_data  <= t_r;
                end else if (t_c == 20) m_s0 <= cmd_operand[15:0];
                else if (t_c == 21) m_s1 <= cmd_operand[4:0];
                else if (t_c == 22) m_s2 <= cmd_operand;
                else if (t_c == 23) m_acc <= 0;
            end
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", cur_tag, what, act, exp);
        end
    endtask

    // compare on every cycle, away from the rising edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("cmd_ready", 32'(cmd_ready), 32'(!m_valid));
            chk("res_valid", 32'(res_valid), 32'(m_valid));
            if (m_valid) chk("res_data", res_data, m_data);
        end
    end

    // called at a falling edge; returns at a falling edge
    task automatic issue(input int code, input logic [31:0] opnd);
        while (!cmd_ready) @(negedge clk);
        cmd_valid   = 1'b1;
        cmd_code    = 6'(code);
        cmd_operand = opnd;
        @(negedge clk);
        cmd_valid   = 1'b0;
        cmd_operand = 32'hDEAD_BEEF;
    endtask

    initial begin
        #500us;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cmd_valid = 1'b0; cmd_code = '0; cmd_operand = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: cleared state after reset
        cur_tag = "R1";
        @(negedge clk);
        issue(4, 32'h0);
        issue(0, 32'd5);
        issue(5, 32'd7);
        issue(2, 32'h8000_0000);

        // R3, R4: staging and multiply
        cur_tag = "R4";
        issue(20, 32'hFFFF_8003);
        issue(0, 32'd1000);
        issue(0, 32'hFFFF_FFF9);
        issue(0, 32'h7FFF_FFFF);
        cur_tag = "R3";
        issue(20, 32'h1234_0007);
        issue(0, 32'd1);

        // R5: accumulate with carry into the upper word
        cur_tag = "R5";
        issue(20, 32'h0000_7FFF);
        for (int i = 0; i < 4; i++) issue(1, 32'h7FFF_FFFF);
        issue(4, 32'h0);
        issue(20, 32'h0000_8000);
        issue(1, 32'h7FFF_FFFF);
        issue(4, 32'h0);

        // R6: clear accumulator
        cur_tag = "R6";
        issue(23, 32'hFFFF_FFFF);
        issue(4, 32'h0);
        issue(1, 32'd3);

        // R7: saturation widths
        cur_tag = "R7";
        issue(21, 32'd0);
        issue(2, 32'h8000_0000);
        issue(21, 32'hFFFF_FFE8);
        issue(2, 32'd200);
        issue(2, 32'hFFFF_FED4);
        issue(2, 32'd100);
        issue(21, 32'd1);
        issue(2, 32'd5);
        issue(2, 32'hFFFF_FFF0);
        issue(21, 32'd31);
        issue(2, 32'h7FFF_FFFF);
        issue(2, 32'h8000_0000);

        // R8: priority encode
        cur_tag = "R8";
        issue(3, 32'h0);
        issue(3, 32'h1);
        issue(3, 32'h8000_0000);
        issue(3, 32'h0001_2345);

        // R9: three-input multiply-add
        cur_tag = "R9";
        issue(20, 32'h0000_0010);
        issue(22, 32'hFFFF_FF00);
        issue(5, 32'd3);
        issue(5, 32'hFFFF_FFFF);

        // R10: reserved result codes
        cur_tag = "R10";
        issue(6, 32'h1234_5678);
        issue(15, 32'hFFFF_FFFF);

        // R2: back-to-back transfers keep ready high, result after result
        cur_tag = "R2";
        issue(20, 32'd3);
        issue(22, 32'd9);
        issue(21, 32'd4);
        issue(0, 32'd2);
        issue(3, 32'h40);

        // R11: ignored and reserved codes, then read state back
        cur_tag = "R11";
        issue(1, 32'd10);
        issue(16, 32'hFFFF_FFFF);
        issue(19, 32'hAAAA_AAAA);
        issue(24, 32'h5555_5555);
        issue(35, 32'hFFFF_FFFF);
        issue(36, 32'h1234_5678);
        issue(63, 32'hFFFF_FFFF);
        issue(0, 32'd1);
        issue(2, 32'd100);
        issue(5, 32'd0);
        issue(4, 32'h0);
        issue(1, 32'd0);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule